// File: doc/BRIEF.md
# Channel Selector to Loop Divide Ratio Generator

This block turns the switch setting of a two-metre handheld radio into the settings for its phase-locked loop. A 2-bit bank code and a channel number from 1 to 12 select one of 48 channel frequencies. A push-to-talk level chooses between receive and transmit. From these the block produces a 14-bit divide count for the loop's programmable divider. It also produces a reference-select bit, which picks a reference of 25 kHz/9 for receive and 25 kHz/8 for transmit.

All arithmetic is in 25 kHz units. A channel frequency F is built from a per-bank base plus 2 units (50 kHz) per channel step. For receive, the 10.7 MHz IF (428 units) is subtracted. For transmit, F is left as it is or moved by 600 kHz (24 units) in the repeater direction of the bank. Outputs are registered. A one-cycle valid strobe marks each new legal result. Illegal channel numbers leave the last result in place.

Top module: `chan_pll_divider`

## Requirements
- R1: While reset is asserted, `div_count_o` is 0 and `ref_tx_o` and `valid_o` are 0.
- R2: Bank codes are 0 = low band A, 1 = high band A, 2 = low band B, 3 = high band B. For channels 1..8, F in 25 kHz units is 5866, 5882, 5865 or 5881 for banks 0..3, plus 2 per channel above 1.
- R3: For channels 9..12, F is 5858, 5898, 5857 or 5897 for banks 0..3, plus 2 per channel above 9.
- R4: When the synchronised push-to-talk is 0, the count is F − 428 and `ref_tx_o` is 0 (divide-by-9 reference).
- R5: When transmitting (`ref_tx_o` = 1) on channels 9..12 of any bank, the count is F.
- R6: When transmitting on channels 1..8 of banks 0 and 2, the count is F − 24.
- R7: When transmitting on channels 1..8 of banks 1 and 3, the count is F + 24.
- R8: Channel numbers 0, 13, 14 and 15 never raise `valid_o`. While such a number is applied, `div_count_o` and `ref_tx_o` keep their last values, even if push-to-talk changes.
- R9: A change of bank or channel to a legal selection shows on the outputs after one rising clock edge, with `valid_o` high for that cycle.
- R10: Push-to-talk passes through a two-flop synchroniser. A change on `ptt_i` reaches `ref_tx_o`, `div_count_o` and `valid_o` on the third rising edge after it.
- R11: `valid_o` is high only in the cycle after the selection changes to a new legal value. It stays low while the inputs are steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bank_i | input | 2 | Bank code |
| chan_i | input | 4 | Channel number, legal 1..12 |
| ptt_i | input | 1 | Push-to-talk level, asynchronous |
| div_count_o | output | 14 | Loop divide count |
| ref_tx_o | output | 1 | 1 = transmit reference (25 kHz/8), 0 = receive (25 kHz/9) |
| valid_o | output | 1 | One-cycle strobe for a new legal result |

## Verification
Several properties are checked on every cycle:
- the count and reference bit hold their values and no strobe appears after an illegal channel;
- a strobe only ever follows a legal selection;
- every strobed count equals the plan frequency, either less the IF or moved by the repeater shift, as the registered reference bit demands;
- every legal frequency falls inside the band;
- the synchroniser output copies the input after its stage delay.

The absolute frequency table for every bank and channel can only be shown by the bench's sweeps of all 48 channels in both directions. The same holds for the exact edge counts for bank, channel and push-to-talk changes, and for the absence of strobes on steady inputs.

// File: rtl/chpll_pkg.sv
package chpll_pkg;

   typedef enum logic [1:0] {
      BANK_LO_A = 2'd0,
      BANK_HI_A = 2'd1,
      BANK_LO_B = 2'd2,
      BANK_HI_B = 2'd3
   } bank_e;

   typedef enum logic [1:0] {
      SH_NONE = 2'd0,
      SH_DOWN = 2'd1,
      SH_UP   = 2'd2
   } shift_e;

   localparam int unsigned FREQ_W    = 14;
   localparam int unsigned BAND_MIN  = 5840;  // 146.000 MHz
   localparam int unsigned BAND_MAX  = 5920;  // 148.000 MHz

   // first repeater channel frequency of each bank, 25 kHz units
   function automatic logic [FREQ_W-1:0] rpt_base(bank_e b);
      case (b)
         BANK_LO_A: rpt_base = FREQ_W'(5866);
         BANK_HI_A: rpt_base = FREQ_W'(5882);
         BANK_LO_B: rpt_base = FREQ_W'(5865);
         default:   rpt_base = FREQ_W'(5881);
      endcase
   endfunction

   // first simplex channel frequency of each bank, 25 kHz units
   function automatic logic [FREQ_W-1:0] spx_base(bank_e b);
      case (b)
         BANK_LO_A: spx_base = FREQ_W'(5858);
         BANK_HI_A: spx_base = FREQ_W'(5898);
         BANK_LO_B: spx_base = FREQ_W'(5857);
         default:   spx_base = FREQ_W'(5897);
      endcase
   endfunction

   // repeater direction: high banks shift up, low banks shift down
   function automatic shift_e rpt_dir(bank_e b);
      case (b)
         BANK_HI_A, BANK_HI_B: rpt_dir = SH_UP;
         default:              rpt_dir = SH_DOWN;
      endcase
   endfunction

endpackage

// File: rtl/chpll_plan.sv
module chpll_plan
   import chpll_pkg::*;
#(
   parameter int unsigned CH_W    = 4,
   parameter int unsigned NUM_CH  = 12,
   parameter int unsigned RPT_CH  = 8,
   parameter int unsigned STEP    = 2
) (
   input  bank_e              bank_i,
   input  logic [CH_W-1:0]    chan_i,
   output logic               legal_o,
   output logic [FREQ_W-1:0]  freq_o,
   output shift_e             shift_o
);

   localparam int unsigned FIRST_SPX = RPT_CH + 1;

   if (NUM_CH >= (1 << CH_W)) begin : g_bad_num_ch
      $error("NUM_CH does not fit in CH_W bits");
   end
   if (RPT_CH == 0 || RPT_CH >= NUM_CH) begin : g_bad_rpt_ch
      $error("RPT_CH must lie between 1 and NUM_CH-1");
   end

   logic              rpt_grp;
   logic [FREQ_W-1:0] ofs;

   always_comb begin
      legal_o = (chan_i != '0) && (int'(chan_i) <= int'(NUM_CH));
      rpt_grp = int'(chan_i) <= int'(RPT_CH);
      if (rpt_grp) begin
         ofs     = FREQ_W'(chan_i) - FREQ_W'(1);
         freq_o  = rpt_base(bank_i) + FREQ_W'(STEP) * ofs;
         shift_o = rpt_dir(bank_i);
      end else begin
         ofs     = FREQ_W'(chan_i) - FREQ_W'(FIRST_SPX);
         freq_o  = spx_base(bank_i) + FREQ_W'(STEP) * ofs;
         shift_o = SH_NONE;
      end
      // R2 R3: every legal selection lands inside the band
      if (legal_o) begin
         band_range_chk: assert (int'(freq_o) >= int'(BAND_MIN) &&
                                 int'(freq_o) <= int'(BAND_MAX));
      end
   end

endmodule

// File: rtl/chpll_sync.sv
module chpll_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("STAGES must be 2 to 4");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], d_i};
   end

   assign q_o = sh_q[STAGES-1];

   // R10
   sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o != $past(q_o)) |-> (q_o == $past(d_i, STAGES)));

endmodule

// File: rtl/chpll_ratio.sv
module chpll_ratio
   import chpll_pkg::*;
#(
   parameter int unsigned IF_UNITS    = 428,
   parameter int unsigned SHIFT_UNITS = 24
) (
   input  logic [FREQ_W-1:0] freq_i,
   input  shift_e            shift_i,
   input  logic              tx_i,
   output logic [FREQ_W-1:0] count_o
);

   if (IF_UNITS >= BAND_MIN) begin : g_bad_if
      $error("IF_UNITS must be below the band floor");
   end
   if (SHIFT_UNITS >= IF_UNITS) begin : g_bad_shift
      $error("SHIFT_UNITS must be below IF_UNITS");
   end

   always_comb begin
      if (!tx_i) begin
         count_o = freq_i - FREQ_W'(IF_UNITS);
      end else begin
         case (shift_i)
            SH_UP:   count_o = freq_i + FREQ_W'(SHIFT_UNITS);
            SH_DOWN: count_o = freq_i - FREQ_W'(SHIFT_UNITS);
            default: count_o = freq_i;
         endcase
      end
   end

endmodule

// File: rtl/chan_pll_divider.sv
module chan_pll_divider
   import chpll_pkg::*;
#(
   parameter int unsigned CH_W        = 4,
   parameter int unsigned NUM_CH      = 12,
   parameter int unsigned RPT_CH      = 8,
   parameter int unsigned IF_UNITS    = 428,
   parameter int unsigned SHIFT_UNITS = 24,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [1:0]        bank_i,
   input  logic [CH_W-1:0]   chan_i,
   input  logic              ptt_i,
   output logic [FREQ_W-1:0] div_count_o,
   output logic              ref_tx_o,
   output logic              valid_o
);

   localparam int unsigned SEL_W = 2 + CH_W + 1;

   logic              ptt_s;
   logic              chan_legal;
   logic [FREQ_W-1:0] plan_freq;
   shift_e            plan_shift;
   logic [FREQ_W-1:0] next_count;
   logic [SEL_W-1:0]  sel, last_sel_q;
   logic              fresh;

   logic [FREQ_W-1:0] count_q;
   logic              ref_q;
   logic              valid_q;

   chpll_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (ptt_i),
      .q_o    (ptt_s)
   );

   chpll_plan #(
      .CH_W   (CH_W),
      .NUM_CH (NUM_CH),
      .RPT_CH (RPT_CH),
      .STEP   (2)
   ) u_plan (
      .bank_i  (bank_e'(bank_i)),
      .chan_i  (chan_i),
      .legal_o (chan_legal),
      .freq_o  (plan_freq),
      .shift_o (plan_shift)
   );

   chpll_ratio #(
      .IF_UNITS    (IF_UNITS),
      .SHIFT_UNITS (SHIFT_UNITS)
   ) u_ratio (
      .freq_i  (plan_freq),
      .shift_i (plan_shift),
      .tx_i    (ptt_s),
      .count_o (next_count)
   );

   assign sel   = {bank_i, chan_i, ptt_s};
   assign fresh = chan_legal && (sel != last_sel_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         last_sel_q <= '0;   // channel 0 never matches a legal selection
         count_q    <= '0;
         ref_q      <= 1'b0;
         valid_q    <= 1'b0;
      end else begin
         last_sel_q <= sel;
         valid_q    <= fresh;
         if (chan_legal) begin
            count_q <= next_count;
            ref_q   <= ptt_s;
         end
      end
   end

   assign div_count_o = count_q;
   assign ref_tx_o    = ref_q;
   assign valid_o     = valid_q;

   // R8
   illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !chan_legal |=> ($stable(div_count_o) && $stable(ref_tx_o) && !valid_o));

   // R11
   strobe_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> $past(chan_legal));

   // R4
   rx_if_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !ref_tx_o) |->
         (int'(div_count_o) + int'(IF_UNITS) == int'($past(plan_freq))));

   // R5 R6 R7
   tx_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && ref_tx_o) |->
         (int'(div_count_o) == int'($past(plan_freq)) +
            (($past(plan_shift) == SH_UP)   ?  int'(SHIFT_UNITS) :
             ($past(plan_shift) == SH_DOWN) ? -int'(SHIFT_UNITS) : 0)));

endmodule

// File: tb/chan_pll_divider_bench.sv
`timescale 1ns/1ps
module chan_pll_divider_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bank = 2'd0;
   logic [3:0]  chan = 4'd0;
   logic        ptt = 1'b0;
   logic [13:0] count;
   logic        ref_tx;
   logic        valid;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   chan_pll_divider u_chan_pll_divider (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bank_i      (bank),
      .chan_i      (chan),
      .ptt_i       (ptt),
      .div_count_o (count),
      .ref_tx_o    (ref_tx),
      .valid_o     (valid)
   );

   // frequency model in kHz, converted to 25 kHz units
   function automatic int model_freq(int b, int c);
      int khz;
      if (c <= 8) begin
         case (b)
            0: khz = 146650;
            1: khz = 147050;
            2: khz = 146625;
            default: khz = 147025;
         endcase
         khz = khz + 50 * (c - 1);
      end else begin
         case (b)
            0: khz = 146450;
            1: khz = 147450;
            2: khz = 146425;
            default: khz = 147425;
         endcase
         khz = khz + 50 * (c - 9);
      end
      return khz / 25;
   endfunction

   function automatic int model_count(int b, int c, bit tx);
      int f = model_freq(b, c);
      if (!tx) return f - 10700 / 25;
      if (c >= 9) return f;
      if (b == 1 || b == 3) return f + 600 / 25;
      return f - 600 / 25;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      bank = 2'd3; chan = 4'd12; ptt = 1'b0;
      rst_n = 1'b0;
      wait_neg(3);
      chk(count == 14'd0, "R1 count in reset", count, 0);
      chk(ref_tx == 1'b0, "R1 ref in reset", ref_tx, 0);
      chk(valid == 1'b0, "R1 valid in reset", valid, 0);
      rst_n = 1'b1;
      wait_neg(4);
   endtask

   // R2 R3 R4 R5 R6 R7 R9 R11: every channel of every bank
   task automatic t_sweep(input bit tx);
      for (int b = 0; b < 4; b++) begin
         for (int c = 1; c <= 12; c++) begin
            bank = 2'(b); chan = 4'(c);
            wait_neg(1);
            chk(valid == 1'b1, "R9 strobe after selection", valid, 1);
            chk(ref_tx == tx, "R4 reference select", ref_tx, tx);
            chk(int'(count) == model_count(b, c, tx),
                tx ? (c >= 9 ? "R5 tx simplex" : ((b % 2) != 0 ? "R7 tx up" : "R6 tx down"))
                   : (c >= 9 ? "R3 rx simplex group" : "R2 rx repeater group"),
                count, model_count(b, c, tx));
            wait_neg(1);
            chk(valid == 1'b0, "R11 no strobe when steady", valid, 0);
         end
      end
   endtask

   task automatic t_ptt_timing();
      bank = 2'd1; chan = 4'd3; ptt = 1'b0;
      wait_neg(5);
      ptt = 1'b1;
      wait_neg(1);
      chk(ref_tx == 1'b0, "R10 ref after 1 edge", ref_tx, 0);
      wait_neg(1);
      chk(ref_tx == 1'b0, "R10 ref after 2 edges", ref_tx, 0);
      chk(valid == 1'b0, "R10 no strobe after 2 edges", valid, 0);
      wait_neg(1);
      chk(ref_tx == 1'b1, "R10 ref after 3 edges", ref_tx, 1);
      chk(valid == 1'b1, "R10 strobe after 3 edges", valid, 1);
      chk(int'(count) == model_count(1, 3, 1'b1), "R10 tx count", count, model_count(1, 3, 1'b1));
      ptt = 1'b0;
      wait_neg(2);
      chk(ref_tx == 1'b1, "R10 release after 2 edges", ref_tx, 1);
      wait_neg(1);
      chk(ref_tx == 1'b0, "R10 release after 3 edges", ref_tx, 0);
      chk(int'(count) == model_count(1, 3, 1'b0), "R10 rx count back", count, model_count(1, 3, 1'b0));
   endtask

   task automatic t_illegal();
      int bad [4] = '{0, 13, 14, 15};
      bank = 2'd2; chan = 4'd5; ptt = 1'b0;
      wait_neg(5);
      for (int i = 0; i < 4; i++) begin
         chan = 4'(bad[i]);
         wait_neg(1);
         chk(valid == 1'b0, "R8 no strobe on illegal channel", valid, 0);
         chk(int'(count) == model_count(2, 5, 1'b0), "R8 count held", count, model_count(2, 5, 1'b0));
         chk(ref_tx == 1'b0, "R8 ref held", ref_tx, 0);
      end
      ptt = 1'b1;
      wait_neg(5);
      chk(ref_tx == 1'b0, "R8 ref held under ptt", ref_tx, 0);
      chk(int'(count) == model_count(2, 5, 1'b0), "R8 count held under ptt", count, model_count(2, 5, 1'b0));
      chk(valid == 1'b0, "R8 no strobe under ptt", valid, 0);
      chan = 4'd5;
      wait_neg(1);
      chk(valid == 1'b1, "R9 strobe on return to legal", valid, 1);
      chk(int'(count) == model_count(2, 5, 1'b1), "R6 tx after illegal", count, model_count(2, 5, 1'b1));
      ptt = 1'b0;
      wait_neg(4);
   endtask

   initial begin
      t_reset();
      t_sweep(1'b0);
      ptt = 1'b1;
      wait_neg(5);
      t_sweep(1'b1);
      ptt = 1'b0;
      wait_neg(5);
      t_ptt_timing();
      t_illegal();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule